// File: doc/BRIEF.md
# Segment Descriptor Presence Checker

This block sits in front of a memory port and vets every access made through a 48-bit data descriptor. Each request carries the descriptor, an element index and a read/write flag. One clock later the block answers with either an access grant and a physical word address, or a single fault code. The fault code separates a block that was never allocated from a block that has been moved out to backing store. It also flags an index that runs past the block's length and a write to a block marked read-only.

The descriptor is split into status flags, an element-size code, a block length counted in elements, and a block base address. For a packed element size, the element index is turned into a word offset by dividing it by the number of elements that fit in one 48-bit word. The fault handler, block allocation and roll-in/roll-out are handled elsewhere. The block only classifies each request and translates its address.

Top module: `seg_desc_checker`

## Requirements
- R1: Descriptor layout: bit 47 present, bit 46 copy, bit 45 indexed, bit 44 paged, bit 43 read-only, bits 42:40 element-size code, bits 39:20 block length in elements, bits 19:0 block base address.
- R2: Every cycle with `req_valid` high is answered in the next cycle by exactly one of `grant_valid` or `fault_valid`. A cycle without a request produces neither in the next cycle.
- R3: A request whose present bit is 0 and whose base address is zero faults with code 1 (unallocated).
- R4: A request whose present bit is 0 and whose base address is nonzero faults with code 2 (rolled out to backing store).
- R5: For a present, non-indexed descriptor, an index greater than or equal to the length faults with code 3 (bounds). A length of zero rejects every index.
- R6: A write through a descriptor with the read-only bit set faults with code 4 (protection). A read through it is granted.
- R7: Only one code is reported, chosen in priority order: presence (1 or 2), then bounds (3), then protection (4).
- R8: On a grant, `phys_addr` is the base plus the word offset, where the offset is the index divided by the elements per word. Size code 1 means 4-bit elements (12 per word), code 2 means 6-bit elements (8 per word), code 3 means 8-bit elements (6 per word). Codes 0 and 4 to 7 mean 48-bit elements (1 per word).
- R9: When the indexed bit is set, the index input is ignored, no bounds check is made, and a grant returns the base address unchanged.
- R10: The copy and paged bits have no effect on the response.
- R11: After reset, and on any idle cycle, the outputs read grant 0, fault 0, code 0 and address 0. A grant carries code 0, and a fault carries address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_desc | input | 48 | Data descriptor |
| req_index | input | 20 | Element index into the block |
| grant_valid | output | 1 | Access granted, one cycle after the request |
| fault_valid | output | 1 | Access refused, one cycle after the request |
| fault_code | output | 3 | 0 none, 1 unallocated, 2 rolled out, 3 bounds, 4 protection |
| phys_addr | output | 20 | Physical word address on a grant |

## Verification
The checker watches every cycle for the properties of the response. It checks that each request gets exactly one response one cycle later and that idle cycles stay silent. It checks that the presence, bounds and protection conditions at the ports produce their codes with the right precedence, and that grants and faults never carry stray values. The address arithmetic for the packed element sizes, the indexed-descriptor bypass, and the fact that the copy and paged bits have no effect are shown only by the bench's scenarios. Those scenarios compare each returned address and code with values computed from the requirements, including back-to-back streams and the edges index = length − 1, index = length and length = 0.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
    localparam int WORD_W = 48;
    localparam int ADDR_W = 20;
    localparam int LEN_W  = 20;
    localparam int IDX_W  = LEN_W;
    localparam int SIZE_W = 3;
    localparam int FLAG_N = 5;
    localparam int DESC_W = FLAG_N + SIZE_W + LEN_W + ADDR_W;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_INIT   = 3'd1,
        FLT_OTHER  = 3'd2,
        FLT_BOUNDS = 3'd3,
        FLT_PROT   = 3'd4
    } fault_e;

    typedef struct packed {
        logic                present;
        logic                copy;
        logic                indexed;
        logic                paged;
        logic                rdonly;
        logic [SIZE_W-1:0]   esize;
        logic [LEN_W-1:0]    length;
        logic [ADDR_W-1:0]   base;
    } desc_t;

    typedef struct packed {
        logic                grant;
        logic                fault;
        fault_e              code;
        logic [ADDR_W-1:0]   addr;
    } resp_t;
endpackage

// File: rtl/sdc_field_decode.sv
module sdc_field_decode
    import sdc_pkg::*;
(
    input  logic [DESC_W-1:0] raw_desc,
    output desc_t             fields
);
    // Field positions follow desc_t; the flag bits occupy the top of the word.
    assign fields = desc_t'(raw_desc);
endmodule

// File: rtl/sdc_addr_xlate.sv
module sdc_addr_xlate
    import sdc_pkg::*;
#(
    parameter int XW_WORD = WORD_W,
    parameter int XW_IDX  = IDX_W,
    parameter int XW_ADDR = ADDR_W
) (
    input  desc_t              d,
    input  logic [XW_IDX-1:0]  index,
    output logic [XW_ADDR-1:0] word_addr,
    output logic               out_of_bounds
);
    localparam int PER_4B = XW_WORD / 4;
    localparam int PER_6B = XW_WORD / 6;
    localparam int PER_8B = XW_WORD / 8;

    logic [XW_IDX-1:0] word_off;

    always_comb begin
        case (d.esize)
            3'd1:    word_off = index / XW_IDX'(PER_4B);
            3'd2:    word_off = index / XW_IDX'(PER_6B);
            3'd3:    word_off = index / XW_IDX'(PER_8B);
            default: word_off = index;
        endcase

        if (d.indexed) begin
            word_addr     = d.base;
            out_of_bounds = 1'b0;
        end else begin
            word_addr     = d.base + XW_ADDR'(word_off);
            out_of_bounds = (index >= XW_IDX'(d.length));
        end
    end
endmodule

// File: rtl/sdc_fault_arb.sv
module sdc_fault_arb
    import sdc_pkg::*;
(
    input  logic   present,
    input  logic   base_zero,
    input  logic   out_of_bounds,
    input  logic   write_to_ro,
    output fault_e code
);
    always_comb begin
        if (!present)
            code = base_zero ? FLT_INIT : FLT_OTHER;
        else if (out_of_bounds)
            code = FLT_BOUNDS;
        else if (write_to_ro)
            code = FLT_PROT;
        else
            code = FLT_NONE;
    end
endmodule

// File: rtl/seg_desc_checker.sv
module seg_desc_checker
    import sdc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [DESC_W-1:0]   req_desc,
    input  logic [IDX_W-1:0]    req_index,
    output logic                grant_valid,
    output logic                fault_valid,
    output logic [2:0]          fault_code,
    output logic [ADDR_W-1:0]   phys_addr
);
    desc_t              fld;
    logic [ADDR_W-1:0]  xaddr;
    logic               oob;
    fault_e             code;
    resp_t              resp_d, resp_q;

    // Copy and paged bits carry no meaning for this check (R10).
    logic unused_flags;
    assign unused_flags = fld.copy ^ fld.paged;

    sdc_field_decode u_decode (
        .raw_desc (req_desc),
        .fields   (fld)
    );

    sdc_addr_xlate u_xlate (
        .d             (fld),
        .index         (req_index),
        .word_addr     (xaddr),
        .out_of_bounds (oob)
    );

    sdc_fault_arb u_arb (
        .present       (fld.present),
        .base_zero     (fld.base == '0),
        .out_of_bounds (oob),
        .write_to_ro   (req_write && fld.rdonly),
        .code          (code)
    );

    always_comb begin
        resp_d = '0;
        if (req_valid) begin
            if (code == FLT_NONE) begin
                resp_d.grant = 1'b1;
                resp_d.addr  = xaddr;
            end else begin
                resp_d.fault = 1'b1;
                resp_d.code  = code;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            resp_q <= '0;
        else
            resp_q <= resp_d;
    end

    assign grant_valid = resp_q.grant;
    assign fault_valid = resp_q.fault;
    assign fault_code  = resp_q.code;
    assign phys_addr   = resp_q.addr;
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker
    import sdc_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_write,
    input logic [DESC_W-1:0]   req_desc,
    input logic [IDX_W-1:0]    req_index,
    input logic                grant_valid,
    input logic                fault_valid,
    input logic [2:0]          fault_code,
    input logic [ADDR_W-1:0]   phys_addr
);
    desc_t d;
    assign d = desc_t'(req_desc);

    p_one_response_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ($countones({grant_valid, fault_valid}) == 1));

    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!grant_valid && !fault_valid));

    p_init_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !d.present && d.base == '0) |=> (fault_valid && fault_code == 3'd1));

    p_other_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !d.present && d.base != '0) |=> (fault_valid && fault_code == 3'd2));

    // R7: bounds wins over protection when both apply
    p_bounds_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && d.present && !d.indexed && req_index >= d.length)
        |=> (fault_valid && fault_code == 3'd3));

    p_prot_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && d.present && req_write && d.rdonly &&
         (d.indexed || req_index < d.length))
        |=> (fault_valid && fault_code == 3'd4));

    p_grant_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (fault_code == 3'd0));

    p_fault_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (phys_addr == '0 && fault_code != 3'd0));
endmodule

bind seg_desc_checker sdc_checker u_sdc_checker (.*);

// File: tb/test_seg_desc_checker.sv
module test_seg_desc_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [47:0] req_desc = '0;
    logic [19:0] req_index = '0;
    logic        grant_valid, fault_valid;
    logic [2:0]  fault_code;
    logic [19:0] phys_addr;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    typedef struct {
        logic        grant;
        logic [2:0]  code;
        logic [19:0] addr;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;   // 125 MHz

    seg_desc_checker i_seg_desc_checker (
        .clk, .rst_n, .req_valid, .req_write, .req_desc, .req_index,
        .grant_valid, .fault_valid, .fault_code, .phys_addr
    );

    function automatic logic [47:0] mk(input logic p, c, ix, pg, ro,
                                       input logic [2:0] sz,
                                       input logic [19:0] len, base);
        return {p, c, ix, pg, ro, sz, len, base};
    endfunction

    function automatic exp_t model(input logic w, input logic [47:0] dsc,
                                   input logic [19:0] idx, input string tag);
        exp_t e;
        int per;
        e.tag = tag; e.grant = 1'b0; e.code = 3'd0; e.addr = '0;
        case (dsc[42:40])
            3'd1: per = 12;
            3'd2: per = 8;
            3'd3: per = 6;
            default: per = 1;
        endcase
        if (!dsc[47])                         e.code = (dsc[19:0] == 0) ? 3'd1 : 3'd2;
        else if (!dsc[45] && idx >= dsc[39:20]) e.code = 3'd3;
        else if (w && dsc[43])                e.code = 3'd4;
        else begin
            e.grant = 1'b1;
            e.addr  = dsc[45] ? dsc[19:0] : dsc[19:0] + 20'(int'(idx) / per);
        end
        return e;
    endfunction

    task automatic send(input logic w, input logic [47:0] dsc,
                        input logic [19:0] idx, input string tag);
        @(posedge clk); #2;
        req_valid = 1'b1; req_write = w; req_desc = dsc; req_index = idx;
        sb.push_back(model(w, dsc, idx, tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            req_valid = 1'b0; req_write = 1'b0; req_desc = '0; req_index = '0;
        end
    endtask

    task automatic check(input bit ok, input string msg, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
        end
    endtask

    // Monitor: pop and compare each response as it appears.
    always @(negedge clk) begin
        if (rst_n && (grant_valid || fault_valid)) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2 response without request", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(grant_valid == e.grant && fault_valid == !e.grant,
                      {e.tag, " grant flag"}, int'(grant_valid), int'(e.grant));
                check(fault_code == e.code, {e.tag, " fault code"},
                      int'(fault_code), int'(e.code));
                check(phys_addr == e.addr, {e.tag, " address"},
                      int'(phys_addr), int'(e.addr));
            end
        end
    end

    initial begin
        for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        check(!grant_valid && !fault_valid && fault_code == 0 && phys_addr == 0,
              "R11 reset outputs", int'(phys_addr), 0);
        #1 rst_n = 1'b1;
        idle(2);
        @(negedge clk);
        check(!grant_valid && !fault_valid, "R2 idle after reset", int'(grant_valid), 0);

        // R1 R8 word elements: base 0x100, len 10
        send(0, mk(1,0,0,0,0,3'd0,20'd10,20'h00100), 20'd5, "R8 word idx5");
        send(0, mk(1,0,0,0,0,3'd0,20'd10,20'h00100), 20'd9, "R5 idx=len-1");
        send(0, mk(1,0,0,0,0,3'd0,20'd10,20'h00100), 20'd10, "R5 idx=len");
        send(1, mk(1,0,0,0,0,3'd0,20'd10,20'h00100), 20'd700, "R5 idx>len");
        send(0, mk(1,0,0,0,0,3'd0,20'd0,20'h00100), 20'd0, "R5 len0");
        // R3 R4 R7 presence
        send(0, mk(0,0,0,0,0,3'd0,20'd10,20'h0), 20'd3, "R3 init");
        send(1, mk(0,0,0,0,1,3'd0,20'd2,20'h0), 20'd50, "R7 init over bounds");
        send(0, mk(0,0,0,0,0,3'd0,20'd10,20'h3ABCD), 20'd1, "R4 other");
        send(1, mk(0,0,0,0,1,3'd0,20'd0,20'h00001), 20'd9, "R7 other over all");
        // R6 R7 protection
        send(1, mk(1,0,0,0,1,3'd0,20'd10,20'h00200), 20'd2, "R6 ro write");
        send(0, mk(1,0,0,0,1,3'd0,20'd10,20'h00200), 20'd2, "R6 ro read");
        send(1, mk(1,0,0,0,1,3'd0,20'd10,20'h00200), 20'd10, "R7 bounds over prot");
        // R8 packed element sizes: 25/12=2, 17/8=2, 13/6=2, code 5 as word
        send(0, mk(1,0,0,0,0,3'd1,20'd100,20'h01000), 20'd25, "R8 4bit");
        send(0, mk(1,0,0,0,0,3'd2,20'd100,20'h01000), 20'd17, "R8 6bit");
        send(0, mk(1,0,0,0,0,3'd3,20'd100,20'h01000), 20'd13, "R8 8bit");
        send(0, mk(1,0,0,0,0,3'd5,20'd100,20'h01000), 20'd13, "R8 code5 word");
        send(0, mk(1,0,0,0,0,3'd1,20'd100,20'h01000), 20'd11, "R8 4bit word0");
        // R9 indexed
        send(0, mk(1,0,1,0,0,3'd0,20'd4,20'h0ABCD), 20'd900, "R9 indexed ignores idx");
        send(1, mk(1,0,1,0,1,3'd0,20'd0,20'h0ABCD), 20'd7, "R9 indexed ro write");
        // R10 copy/paged
        send(0, mk(1,1,0,1,0,3'd0,20'd10,20'h00100), 20'd5, "R10 copy paged grant");
        send(0, mk(1,1,0,1,0,3'd0,20'd10,20'h00100), 20'd10, "R10 copy paged bounds");
        send(0, mk(0,1,0,1,0,3'd0,20'd10,20'h0), 20'd0, "R10 copy paged init");
        idle(1);
        @(negedge clk);
        idle(3);
        @(negedge clk);
        check(!grant_valid && !fault_valid && fault_code == 0 && phys_addr == 0,
              "R11 idle outputs", int'(fault_code), 0);
        check(sb.size() == 0, "R2 all requests answered", sb.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule